// File: doc/BRIEF.md
# Multicycle Processor Sequencing Controller

This block is the Moore-style sequencer of a 32-bit load/store processor that executes each instruction over several clock cycles. It watches the 6-bit opcode held in the instruction register and walks through ten numbered states, 0 to 9. In each state it drives a fixed set of datapath controls: memory strobes, register-file and instruction-register loads, program-counter updates, and the selects for the ALU operands, ALU operation, write-back source and next-PC source.

Every instruction starts with a fetch state and a decode state. After decode, each class follows its own short path:

| Class | States | Cycles |
|---|---|---|
| Load | 0, 1, 2, 3, 4 | 5 |
| Store | 0, 1, 2, 5 | 4 |
| Register-to-register | 0, 1, 6, 7 | 4 |
| Branch-on-equal | 0, 1, 8 | 3 |
| Jump | 0, 1, 9 | 3 |

Any control the current state does not use is held at 0. The outputs therefore depend on the state alone.

Top module: `mcc_ctrl_fsm`

## Requirements
- R1: While `rst_n` is low, the outputs show the fetch controls at once, with no clock edge needed. After release, the first cycle is a fetch.
- R2: Fetch (state 0) sets `mem_rd=1`, `ir_load=1`, `pc_wr_en=1` and `alu_b_sel=01`. It clears `addr_from_alu`, `alu_a_sel`, `alu_op_sel` and `pc_src_sel` to 0. Fetch always moves to decode.
- R3: Decode (state 1) sets `alu_b_sel=11` with `alu_a_sel=0` and `alu_op_sel=00`. It dispatches on the opcode: 100011 (load) and 101011 (store) go to state 2, 000000 (register op) goes to state 6, 000100 (branch) goes to state 8, and 000010 (jump) goes to state 9.
- R4: A load runs states 0, 1, 2, 3, 4 and then returns to fetch. State 2 sets `alu_a_sel=1` and `alu_b_sel=10`. State 3 sets `mem_rd=1` and `addr_from_alu=1`. State 4 sets `rf_wr_en=1`, `wb_from_mem=1` and `rf_dst_rd=0`.
- R5: A store runs states 0, 1, 2, 5 and then returns to fetch. State 5 sets `mem_wr=1` and `addr_from_alu=1`.
- R6: A register op runs states 0, 1, 6, 7 and then returns to fetch. State 6 sets `alu_a_sel=1`, `alu_b_sel=00` and `alu_op_sel=10`. State 7 sets `rf_wr_en=1` and `rf_dst_rd=1`, with `wb_from_mem=0`.
- R7: A branch runs states 0, 1, 8 and then returns to fetch. State 8 sets `alu_a_sel=1`, `alu_op_sel=01`, `pc_src_sel=01` and `pc_wr_cond=1`.
- R8: A jump runs states 0, 1, 9 and then returns to fetch. State 9 sets `pc_src_sel=10` and `pc_wr_en=1`.
- R9: An opcode outside the five listed goes from decode straight back to fetch, so the instruction takes 2 cycles.
- R10: Every control that a state does not name is 0. In particular, `pc_wr_cond` is high only in state 8.
- R11: The opcode is read only in states 1 and 2. Changing it in any other state does not change the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| opcode | input | 6 | Opcode field of the instruction register |
| pc_wr_en | output | 1 | Unconditional program-counter load |
| pc_wr_cond | output | 1 | Program-counter load that the datapath qualifies with its equal flag |
| addr_from_alu | output | 1 | Memory address comes from the ALU result register (0 selects the PC) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_load | output | 1 | Instruction register load |
| wb_from_mem | output | 1 | Register write data comes from the memory data register (0 selects the ALU result) |
| pc_src_sel | output | 2 | Next-PC source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_op_sel | output | 2 | ALU operation class: 00 add, 01 compare, 10 function field |
| alu_a_sel | output | 1 | ALU A operand: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B operand: 00 register B, 01 constant 4, 10 offset, 11 shifted offset |
| rf_wr_en | output | 1 | Register-file write enable |
| rf_dst_rd | output | 1 | Destination register from the rd field (0 selects the rt field) |

## Verification
Each state has its own control pattern, so a wrong state register shows at the outputs in the same cycle it is entered. The bench compares the outputs every cycle against the expected state trace for each instruction class. A wrong dispatch or a missed return to fetch therefore fails at the first cycle after decode, or at the first cycle after the last state. Opcodes changed late in an instruction, unknown opcodes, and a reset applied in mid-instruction show whether the sequence depends only on the states that are meant to read the opcode.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  localparam int OPC_W = 6;
  localparam int ST_W  = 4;

  localparam logic [OPC_W-1:0] OPC_REG    = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE  = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_JUMP   = 6'b000010;

  typedef enum logic [ST_W-1:0] {
    ST_FETCH   = 4'd0,
    ST_DECODE  = 4'd1,
    ST_ADDR    = 4'd2,
    ST_LDREAD  = 4'd3,
    ST_LDWB    = 4'd4,
    ST_STWRITE = 4'd5,
    ST_EXEC    = 4'd6,
    ST_RWB     = 4'd7,
    ST_BRANCH  = 4'd8,
    ST_JUMP    = 4'd9
  } st_e;

  typedef struct packed {
    logic       pc_wr_en;
    logic       pc_wr_cond;
    logic       addr_from_alu;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_load;
    logic       wb_from_mem;
    logic [1:0] pc_src_sel;
    logic [1:0] alu_op_sel;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic       rf_wr_en;
    logic       rf_dst_rd;
  } ctrl_t;
endpackage

// File: rtl/mcc_next_state.sv
module mcc_next_state
  import mcc_pkg::*;
(
  input  st_e              cur,
  input  logic [OPC_W-1:0] opcode,
  output st_e              nxt
);
  always_comb begin
    nxt = ST_FETCH;
    unique case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        if (opcode == OPC_LOAD || opcode == OPC_STORE) nxt = ST_ADDR;
        else if (opcode == OPC_REG)                    nxt = ST_EXEC;
        else if (opcode == OPC_BRANCH)                 nxt = ST_BRANCH;
        else if (opcode == OPC_JUMP)                   nxt = ST_JUMP;
        else                                           nxt = ST_FETCH;
      end
      ST_ADDR: begin
        if (opcode == OPC_LOAD)       nxt = ST_LDREAD;
        else if (opcode == OPC_STORE) nxt = ST_STWRITE;
        else                          nxt = ST_FETCH;
      end
      ST_LDREAD: nxt = ST_LDWB;
      ST_EXEC:   nxt = ST_RWB;
      default:   nxt = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mcc_ctrl_rom.sv
module mcc_ctrl_rom
  import mcc_pkg::*;
(
  input  st_e   cur,
  output ctrl_t ctl
);
  always_comb begin
    ctl = '0;
    unique case (cur)
      ST_FETCH: begin
        ctl.mem_rd    = 1'b1;
        ctl.ir_load   = 1'b1;
        ctl.pc_wr_en  = 1'b1;
        ctl.alu_b_sel = 2'b01;
      end
      ST_DECODE:  ctl.alu_b_sel = 2'b11;
      ST_ADDR: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = 2'b10;
      end
      ST_LDREAD: begin
        ctl.mem_rd        = 1'b1;
        ctl.addr_from_alu = 1'b1;
      end
      ST_LDWB: begin
        ctl.rf_wr_en    = 1'b1;
        ctl.wb_from_mem = 1'b1;
      end
      ST_STWRITE: begin
        ctl.mem_wr        = 1'b1;
        ctl.addr_from_alu = 1'b1;
      end
      ST_EXEC: begin
        ctl.alu_a_sel  = 1'b1;
        ctl.alu_op_sel = 2'b10;
      end
      ST_RWB: begin
        ctl.rf_wr_en  = 1'b1;
        ctl.rf_dst_rd = 1'b1;
      end
      ST_BRANCH: begin
        ctl.alu_a_sel  = 1'b1;
        ctl.alu_op_sel = 2'b01;
        ctl.pc_src_sel = 2'b01;
        ctl.pc_wr_cond = 1'b1;
      end
      ST_JUMP: begin
        ctl.pc_src_sel = 2'b10;
        ctl.pc_wr_en   = 1'b1;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/mcc_state_reg.sv
module mcc_state_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/mcc_ctrl_fsm.sv
module mcc_ctrl_fsm
  import mcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  output logic             pc_wr_en,
  output logic             pc_wr_cond,
  output logic             addr_from_alu,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             ir_load,
  output logic             wb_from_mem,
  output logic [1:0]       pc_src_sel,
  output logic [1:0]       alu_op_sel,
  output logic             alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic             rf_wr_en,
  output logic             rf_dst_rd
);
  logic [ST_W-1:0] st_q;
  st_e             cur_st;
  st_e             nxt_st;
  ctrl_t           ctl;
  logic            step_en;

  assign step_en = 1'b1;
  assign cur_st  = st_e'(st_q);

  mcc_next_state u_next (
    .cur    (cur_st),
    .opcode (opcode),
    .nxt    (nxt_st)
  );

  mcc_state_reg #(.W(ST_W)) u_sreg (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (step_en),
    .d     (nxt_st),
    .q     (st_q)
  );

  mcc_ctrl_rom u_rom (
    .cur (cur_st),
    .ctl (ctl)
  );

  assign pc_wr_en      = ctl.pc_wr_en;
  assign pc_wr_cond    = ctl.pc_wr_cond;
  assign addr_from_alu = ctl.addr_from_alu;
  assign mem_rd        = ctl.mem_rd;
  assign mem_wr        = ctl.mem_wr;
  assign ir_load       = ctl.ir_load;
  assign wb_from_mem   = ctl.wb_from_mem;
  assign pc_src_sel    = ctl.pc_src_sel;
  assign alu_op_sel    = ctl.alu_op_sel;
  assign alu_a_sel     = ctl.alu_a_sel;
  assign alu_b_sel     = ctl.alu_b_sel;
  assign rf_wr_en      = ctl.rf_wr_en;
  assign rf_dst_rd     = ctl.rf_dst_rd;
endmodule

// File: rtl/mcc_ctrl_chk.sv
module mcc_ctrl_chk
  import mcc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [OPC_W-1:0] opcode,
  input logic             pc_wr_en,
  input logic             pc_wr_cond,
  input logic             addr_from_alu,
  input logic             mem_rd,
  input logic             mem_wr,
  input logic             ir_load,
  input logic             wb_from_mem,
  input logic [1:0]       pc_src_sel,
  input logic             rf_wr_en
);
  logic op_known;
  assign op_known = (opcode == OPC_REG) || (opcode == OPC_LOAD) || (opcode == OPC_STORE)
                 || (opcode == OPC_BRANCH) || (opcode == OPC_JUMP);

  AST_RESET_SHOWS_FETCH: assert property (@(posedge clk) !rst_n |-> ir_load && mem_rd); // R1
  AST_FETCH_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |-> mem_rd && pc_wr_en && !addr_from_alu && pc_src_sel == 2'b00); // R2
  AST_FETCH_THEN_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |=> !ir_load && !mem_rd && !pc_wr_en); // R3
  AST_LOAD_READ_THEN_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && addr_from_alu) |=> rf_wr_en && wb_from_mem); // R4
  AST_STORE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> ir_load); // R5
  AST_WB_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |=> ir_load); // R6
  AST_BRANCH_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_cond |=> ir_load); // R7
  AST_JUMP_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr_en && pc_src_sel == 2'b10) |=> ir_load); // R8
  AST_UNKNOWN_OP_REFETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_load && !op_known) |=> ##1 ir_load); // R9
  AST_COND_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_cond |-> !pc_wr_en && !mem_wr && !rf_wr_en && !mem_rd); // R10
endmodule

bind mcc_ctrl_fsm mcc_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .opcode        (opcode),
  .pc_wr_en      (pc_wr_en),
  .pc_wr_cond    (pc_wr_cond),
  .addr_from_alu (addr_from_alu),
  .mem_rd        (mem_rd),
  .mem_wr        (mem_wr),
  .ir_load       (ir_load),
  .wb_from_mem   (wb_from_mem),
  .pc_src_sel    (pc_src_sel),
  .rf_wr_en      (rf_wr_en)
);

// File: tb/tb_mcc_ctrl_fsm.sv
module tb_mcc_ctrl_fsm;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] opcode;
  logic       pc_wr_en, pc_wr_cond, addr_from_alu, mem_rd, mem_wr, ir_load;
  logic       wb_from_mem, alu_a_sel, rf_wr_en, rf_dst_rd;
  logic [1:0] pc_src_sel, alu_op_sel, alu_b_sel;

  int total = 0;
  int bad   = 0;
  int we_act = 0;
  int we_exp = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [15:0] vec;
    string       req;
    int          st;
  } item_t;
  item_t sbq[$];

  always #5 clk = ~clk;

  mcc_ctrl_fsm dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode),
    .pc_wr_en(pc_wr_en), .pc_wr_cond(pc_wr_cond), .addr_from_alu(addr_from_alu),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_load(ir_load), .wb_from_mem(wb_from_mem),
    .pc_src_sel(pc_src_sel), .alu_op_sel(alu_op_sel), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .rf_wr_en(rf_wr_en), .rf_dst_rd(rf_dst_rd)
  );

  // {pc_wr, cond, addr, rd, wr, irld, wbmem, src[2], op[2], a, b[2], rfwr, dst}
  function automatic logic [15:0] exp_vec(int st);
    case (st)
      0: return 16'b1_0_0_1_0_1_0_00_00_0_01_0_0;
      1: return 16'b0_0_0_0_0_0_0_00_00_0_11_0_0;
      2: return 16'b0_0_0_0_0_0_0_00_00_1_10_0_0;
      3: return 16'b0_0_1_1_0_0_0_00_00_0_00_0_0;
      4: return 16'b0_0_0_0_0_0_1_00_00_0_00_1_0;
      5: return 16'b0_0_1_0_1_0_0_00_00_0_00_0_0;
      6: return 16'b0_0_0_0_0_0_0_00_10_1_00_0_0;
      7: return 16'b0_0_0_0_0_0_0_00_00_0_00_1_1;
      8: return 16'b0_1_0_0_0_0_0_01_01_1_00_0_0;
      9: return 16'b1_0_0_0_0_0_0_10_00_0_00_0_0;
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [15:0] act_vec();
    return {pc_wr_en, pc_wr_cond, addr_from_alu, mem_rd, mem_wr, ir_load, wb_from_mem,
            pc_src_sel, alu_op_sel, alu_a_sel, alu_b_sel, rf_wr_en, rf_dst_rd};
  endfunction

  function automatic int n_writes(logic [15:0] v);
    return int'(v[15]) + int'(v[14]) + int'(v[11]) + int'(v[10]) + int'(v[1]);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per cycle, away from the rising edge
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      we_act += n_writes(act_vec());
      we_exp += n_writes(it.vec);
      check($sformatf("%s state%0d", it.req, it.st), act_vec(), it.vec);
    end
  end

  // driver: called just after the edge that enters fetch
  task automatic run(logic [5:0] op, string req, bit late);
    int sts[$];
    sts.push_back(0);
    sts.push_back(1);
    case (op)
      6'b100011: begin sts.push_back(2); sts.push_back(3); sts.push_back(4); end
      6'b101011: begin sts.push_back(2); sts.push_back(5); end
      6'b000000: begin sts.push_back(6); sts.push_back(7); end
      6'b000100: sts.push_back(8);
      6'b000010: sts.push_back(9);
      default: ;
    endcase
    opcode = op;
    foreach (sts[i]) begin
      item_t it;
      it.vec = exp_vec(sts[i]);
      it.st  = sts[i];
      it.req = (sts[i] == 0) ? "R2" : (sts[i] == 1) ? "R3" : req;
      sbq.push_back(it);
    end
    if (late && sts.size() > 2) begin
      repeat (sts.size() - 1) @(posedge clk);
      #1 opcode = 6'h3F;
      @(posedge clk);
      #1;
    end else begin
      repeat (sts.size()) @(posedge clk);
      #1;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n  = 1'b0;
    opcode = 6'b000000;
    @(negedge clk);
    check("R1 reset", act_vec(), exp_vec(0));
    @(posedge clk);
    #1 rst_n = 1'b1;

    run(6'b000000, "R6", 1'b0);
    run(6'b100011, "R4", 1'b0);
    run(6'b101011, "R5", 1'b0);
    run(6'b000100, "R7", 1'b0);
    run(6'b000010, "R8", 1'b0);
    run(6'b111111, "R9", 1'b0);
    run(6'b000001, "R9", 1'b0);
    run(6'b100011, "R4", 1'b0);
    run(6'b101011, "R5", 1'b0);
    // opcode changed in the last state of each path
    run(6'b000000, "R11", 1'b1);
    run(6'b100011, "R11", 1'b1);
    run(6'b101011, "R11", 1'b1);
    run(6'b000100, "R11", 1'b1);
    run(6'b000010, "R11", 1'b1);
    run(6'b000100, "R7", 1'b0);

    // reset in the middle of a load
    opcode = 6'b100011;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b0;
    #1 check("R1 async", act_vec(), exp_vec(0));
    @(posedge clk);
    #1 rst_n = 1'b1;
    run(6'b000010, "R1", 1'b0);
    run(6'b000000, "R6", 1'b0);

    total++;
    if (we_act != we_exp) begin
      bad++;
      $display("FAIL R10 write-enable count: actual=%0d expected=%0d", we_act, we_exp);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule